// File: doc/BRIEF.md
# GPIO Interrupt Trigger and Routing Unit

This unit watches a group of general-purpose inputs, arranged as several ports that share one interrupt group. Every pin is synchronised to the local clock and then checked against a trigger condition chosen per pin. The condition can be a rising edge, a falling edge, both edges, a high level or a low level. Edge events are held in a sticky pending bit. Level conditions are reported live.

Each pin is steered to exactly one of several interrupt outputs of the group. Each output is an active-high level: it is the OR of the enabled, pending pins that are routed to it. Different processors can therefore each own a subset of pins. Software reaches the unit through a small register port. Through this port it sets the trigger code, enable and output choice for each pin. It reads one status view per output, and it clears edge events by writing 1.

Top module: `gpio_irq_router`

## Requirements
- R1: Each input passes through a two-flop synchroniser. A change on a level-configured pin is not visible in status after the first rising clock edge, and is visible after the second.
- R2: Trigger code 1 latches a pending bit on a rising edge, code 2 on a falling edge, and code 3 on either edge. Edges are found by comparing the synchronised value with its value one clock earlier.
- R3: Code 4 makes the status bit follow the synchronised input. Code 8 makes it follow the inverse. Writing 1 to such a bit has no effect.
- R4: Any other trigger code (0, 5-7, 9-15) leaves the pin's status at 0 and never raises an interrupt.
- R5: An edge pending bit stays set until 1 is written to its bit in the status register of its output. Writing 0 leaves it set.
- R6: If a clear write and a new edge on the same pin fall in the same clock, the pending bit stays set.
- R7: Config bits [8 +: SEL_W] select the output of a pin. Out-of-range values select output 0. Status register k at address STAT_BASE+k (16+k by default) shows in bit i only pins routed to output k. A clear written there affects only those pins.
- R8: irq_out[k] is high exactly when some enabled pin routed to output k has its status bit set.
- R9: Config bit 4 is the per-pin enable. With it at 0 the status bit is still recorded and readable, but it does not drive irq_out.
- R10: After reset all config words are 0: trigger disabled, enable 0, output 0. All status reads return 0 and every irq_out is low.
- R11: Writing a pin's config word clears its edge pending bit, even when an edge arrives in that clock.
- R12: The config word of pin i is at address i and reads back as {select, enable, trigger} in bits [8 +: SEL_W], [4] and [3:0]. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NUM_PORTS*PINS_PER_PORT | Asynchronous pin inputs, pin i in bit i |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| irq_out | output | NUM_OUTS | Level interrupt outputs of the group |

## Verification
The bench aims a clear write at the exact clock in which a both-edge pin sees a new edge. A design that gave the clear priority would lose that event and read back 0. It writes 1 to level-triggered bits and writes clears through the wrong output's status address. A design that cleared across outputs, or latched level events, would drop or keep a bit it should not. It also checks the sync latency at the first and second edge. It masks pins whose status must still read 1. It uses illegal codes, such as 5, that share bits with legal ones. A decoder that tested single bits instead of the whole code would then report edges or levels.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [3:0] TRIG_RISE = 4'd1;
  localparam logic [3:0] TRIG_FALL = 4'd2;
  localparam logic [3:0] TRIG_BOTH = 4'd3;
  localparam logic [3:0] TRIG_HIGH = 4'd4;
  localparam logic [3:0] TRIG_LOW  = 4'd8;

  localparam int CFG_EN_BIT  = 4;
  localparam int CFG_SEL_LSB = 8;

  function automatic logic trig_is_edge(logic [3:0] code);
    return (code == TRIG_RISE) || (code == TRIG_FALL) || (code == TRIG_BOTH);
  endfunction

  function automatic logic trig_is_legal(logic [3:0] code);
    return trig_is_edge(code) || (code == TRIG_HIGH) || (code == TRIG_LOW);
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_now,
  output logic [WIDTH-1:0] sync_prev
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] now_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      now_q  <= meta_q;
      prev_q <= now_q;
    end
  end

  assign sync_now  = now_q;
  assign sync_prev = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_now,
  input  logic       pin_prev,
  input  logic [3:0] trig,
  input  logic       clr_req,
  input  logic       cfg_wr,
  output logic       status
);
  logic rise, fall, hit;
  logic pend_q, pend_d, pend_en;

  assign rise = pin_now & ~pin_prev;
  assign fall = ~pin_now & pin_prev;

  always_comb begin
    unique case (trig)
      TRIG_RISE: hit = rise;
      TRIG_FALL: hit = fall;
      TRIG_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_comb begin
    pend_en = cfg_wr | hit | clr_req;
    if (cfg_wr)      pend_d = 1'b0;
    else if (hit)    pend_d = 1'b1;
    else             pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_comb begin
    if (trig_is_edge(trig))   status = pend_q;
    else if (trig == TRIG_HIGH) status = pin_now;
    else if (trig == TRIG_LOW)  status = ~pin_now;
    else                      status = 1'b0;
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int NPINS    = 8,
  parameter int NUM_OUTS = 2,
  parameter int SEL_W    = 1
) (
  input  logic [NPINS-1:0]                pin_stat,
  input  logic [NPINS-1:0]                pin_en,
  input  logic [NPINS-1:0][SEL_W-1:0]     pin_sel,
  output logic [NUM_OUTS-1:0][NPINS-1:0]  stat_view,
  output logic [NUM_OUTS-1:0]             irq
);
  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign stat_view[k][i] = pin_stat[i] && (pin_sel[i] == SEL_W'(k));
    end
    assign irq[k] = |(stat_view[k] & pin_en);
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int PINS_PER_PORT = 4,
  parameter int NUM_OUTS      = 2,
  parameter int ADDR_W        = 5,
  parameter int DATA_W        = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] gpio_in,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic [ADDR_W-1:0]                  rd_addr,
  output logic [DATA_W-1:0]                  rd_data,
  output logic [NUM_OUTS-1:0]                irq_out
);
  localparam int NPINS     = NUM_PORTS * PINS_PER_PORT;
  localparam int SEL_W     = (NUM_OUTS > 1) ? $clog2(NUM_OUTS) : 1;
  localparam int STAT_BASE = 2 ** (ADDR_W - 1);

  logic [NPINS-1:0]               sync_now, sync_prev;
  logic [NPINS-1:0][3:0]          trig_q, trig_d;
  logic [NPINS-1:0]               en_q, en_d;
  logic [NPINS-1:0][SEL_W-1:0]    sel_q, sel_d;
  logic [NPINS-1:0]               cfgwr_vec, clr_vec, pin_stat;
  logic [NUM_OUTS-1:0][NPINS-1:0] stat_view;
  logic [SEL_W-1:0]               sel_fld;

  gpio_irq_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(gpio_in),
    .sync_now(sync_now), .sync_prev(sync_prev)
  );

  // Register write decode: config words and write-1-to-clear per output view.
  assign sel_fld = wr_data[CFG_SEL_LSB +: SEL_W];

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      cfgwr_vec[i] = wr_en && (wr_addr == ADDR_W'(i));
      clr_vec[i]   = wr_en && wr_data[i] &&
                     (wr_addr == ADDR_W'(STAT_BASE + int'(sel_q[i])));
      trig_d[i]    = wr_data[3:0];
      en_d[i]      = wr_data[CFG_EN_BIT];
      sel_d[i]     = (int'(sel_fld) < NUM_OUTS) ? sel_fld : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      en_q   <= '0;
      sel_q  <= '0;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        if (cfgwr_vec[i]) begin
          trig_q[i] <= trig_d[i];
          en_q[i]   <= en_d[i];
          sel_q[i]  <= sel_d[i];
        end
      end
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_det
    gpio_irq_detect u_det (
      .clk(clk), .rst_n(rst_n),
      .pin_now(sync_now[i]), .pin_prev(sync_prev[i]),
      .trig(trig_q[i]), .clr_req(clr_vec[i]), .cfg_wr(cfgwr_vec[i]),
      .status(pin_stat[i])
    );
  end

  gpio_irq_route #(.NPINS(NPINS), .NUM_OUTS(NUM_OUTS), .SEL_W(SEL_W)) u_route (
    .pin_stat(pin_stat), .pin_en(en_q), .pin_sel(sel_q),
    .stat_view(stat_view), .irq(irq_out)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (rd_addr == ADDR_W'(i)) begin
        rd_data[3:0]                  = trig_q[i];
        rd_data[CFG_EN_BIT]           = en_q[i];
        rd_data[CFG_SEL_LSB +: SEL_W] = sel_q[i];
      end
    end
    for (int k = 0; k < NUM_OUTS; k++) begin
      if (rd_addr == ADDR_W'(STAT_BASE + k)) rd_data[NPINS-1:0] = stat_view[k];
    end
  end
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int NUM_OUTS = 2
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NPINS-1:0][3:0]             trig_q,
  input logic [NPINS-1:0]                  pin_stat,
  input logic [NPINS-1:0]                  clr_vec,
  input logic [NPINS-1:0]                  cfgwr_vec,
  input logic [NUM_OUTS-1:0][NPINS-1:0]    stat_view,
  input logic [NUM_OUTS-1:0]               irq_out
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [NUM_OUTS-1:0] col;
    for (genvar k = 0; k < NUM_OUTS; k++) begin : g_col
      assign col[k] = stat_view[k][i];
    end

    assert_single_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));

    assert_illegal_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_is_legal(trig_q[i]) |-> !pin_stat[i]);

    assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_is_edge(trig_q[i]) && pin_stat[i] && !clr_vec[i] && !cfgwr_vec[i])
      |=> pin_stat[i]);

    assert_cfg_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfgwr_vec[i] |=> !(trig_is_edge(trig_q[i]) && pin_stat[i]));
  end

  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
    assert_irq_has_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[k] |-> (|stat_view[k]));
  end
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NPINS(NPINS), .NUM_OUTS(NUM_OUTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_q(trig_q), .pin_stat(pin_stat),
  .clr_vec(clr_vec), .cfgwr_vec(cfgwr_vec), .stat_view(stat_view), .irq_out(irq_out)
);

// File: tb/gpio_irq_router_bench.sv
`timescale 1ns/1ps
module gpio_irq_router_bench;
  localparam int NP = 8;
  localparam int NO = 2;
  localparam int SB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] gpio_in = '0;
  logic          wr_en = 1'b0;
  logic [4:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [4:0]    rd_addr = '0;
  logic [15:0]   rd_data;
  logic [NO-1:0] irq_out;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gpio_irq_router u_gpio_irq_router (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 5'(a);
    #0.5;
    v = int'(rd_data);
  endtask

  function automatic bit exp_pin(input int code, input bit oldv, input bit newv);
    case (code)
      1: return !oldv && newv;
      2: return oldv && !newv;
      3: return oldv != newv;
      4: return newv;
      8: return !newv;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int v;
    int codes[8] = '{0, 1, 2, 3, 4, 8, 5, 12};
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R10 reset state
    chk("R10 irq", int'(irq_out), 0);
    rd(0, v);      chk("R10 cfg0", v, 0);
    rd(SB, v);     chk("R10 stat0", v, 0);
    rd(SB + 1, v); chk("R10 stat1", v, 0);

    // R1 latency on a level-high pin (pin1), R12 readback
    wr(1, 16'h14);
    rd(1, v); chk("R12 cfg readback", v, 16'h14);
    rd(9, v); chk("R12 unmapped", v, 0);
    gpio_in[1] = 1'b1;
    tick(1); rd(SB, v); chk("R1 after one edge", (v >> 1) & 1, 0);
    tick(1); rd(SB, v); chk("R1 after two edges", (v >> 1) & 1, 1);

    // R2/R5/R8 rising pin0
    wr(0, 16'h11);
    gpio_in[0] = 1'b1; tick(4);
    rd(SB, v); chk("R2 rise", v & 1, 1);
    chk("R8 irq0", int'(irq_out[0]), 1);
    gpio_in[0] = 1'b0; tick(4);
    rd(SB, v); chk("R5 sticky over fall", v & 1, 1);
    wr(SB, 0); rd(SB, v); chk("R5 write 0 keeps", v & 1, 1);
    wr(SB, 1); rd(SB, v); chk("R5 write 1 clears", v & 1, 0);
    // R3 level not clearable
    wr(SB, 2); rd(SB, v); chk("R3 level ignores clear", (v >> 1) & 1, 1);
    gpio_in[1] = 1'b0; tick(4);
    rd(SB, v); chk("R3 level follows", (v >> 1) & 1, 0);
    chk("R8 irq0 low", int'(irq_out[0]), 0);

    // R2 both edges on pin2, R6 collision
    wr(2, 16'h13);
    gpio_in[2] = 1'b1; tick(4);
    rd(SB, v); chk("R2 both rise", (v >> 2) & 1, 1);
    wr(SB, 4);
    gpio_in[2] = 1'b0; tick(4);
    rd(SB, v); chk("R2 both fall", (v >> 2) & 1, 1);
    gpio_in[2] = 1'b1; tick(2);
    wr(SB, 4);
    rd(SB, v); chk("R6 edge beats clear", (v >> 2) & 1, 1);
    wr(SB, 4); rd(SB, v); chk("R6 later clear", (v >> 2) & 1, 0);

    // R2 falling pin3, R11 config clears
    wr(3, 16'h12);
    gpio_in[3] = 1'b1; tick(4);
    rd(SB, v); chk("R2 fall ignores rise", (v >> 3) & 1, 0);
    gpio_in[3] = 1'b0; tick(4);
    rd(SB, v); chk("R2 fall", (v >> 3) & 1, 1);
    wr(3, 16'h12); rd(SB, v); chk("R11 cfg write clears", (v >> 3) & 1, 0);

    // R7 routing pin4 to output 1
    wr(4, 16'h111);
    gpio_in[4] = 1'b1; tick(4);
    rd(SB + 1, v); chk("R7 view1", v, 16'h10);
    rd(SB, v);     chk("R7 view0 excludes", (v >> 4) & 1, 0);
    chk("R8 irq1", int'(irq_out[1]), 1);
    wr(SB, 16'h10); rd(SB + 1, v); chk("R7 wrong view clear", v, 16'h10);
    wr(SB + 1, 16'h10); rd(SB + 1, v); chk("R7 own view clear", v, 0);

    // R9 enable mask, pin5 level-low on output 1
    wr(5, 16'h108);
    tick(4);
    rd(SB + 1, v); chk("R9 status recorded", (v >> 5) & 1, 1);
    chk("R9 irq masked", int'(irq_out[1]), 0);
    wr(5, 16'h118);
    chk("R9 irq enabled", int'(irq_out[1]), 1);

    // R4 illegal codes
    wr(6, 16'h15); wr(7, 16'h1C);
    gpio_in[7:6] = 2'b11; tick(4); gpio_in[7:6] = 2'b00; tick(4);
    rd(SB, v); chk("R4 illegal quiet", (v >> 6) & 3, 0);

    // Random phase
    for (int it = 0; it < 30; it++) begin
      int cd[NP]; bit en[NP]; int sl[NP];
      logic [NP-1:0] ov, nv;
      int e0, e1, i0, i1;
      ov = NP'($urandom); nv = NP'($urandom);
      for (int i = 0; i < NP; i++) begin
        cd[i] = codes[$urandom % 8];
        en[i] = 1'($urandom);
        sl[i] = int'($urandom % 2);
        wr(i, (sl[i] << 8) | (int'(en[i]) << 4) | cd[i]);
      end
      gpio_in = ov; tick(5);
      wr(SB, 16'hFF); wr(SB + 1, 16'hFF);
      gpio_in = nv; tick(5);
      e0 = 0; e1 = 0; i0 = 0; i1 = 0;
      for (int i = 0; i < NP; i++) begin
        if (exp_pin(cd[i], ov[i], nv[i])) begin
          if (sl[i] == 0) begin e0 |= (1 << i); if (en[i]) i0 = 1; end
          else            begin e1 |= (1 << i); if (en[i]) i1 = 1; end
        end
      end
      rd(SB, v);     chk("R2 R3 R7 random view0", v, e0);
      rd(SB + 1, v); chk("R2 R3 R7 random view1", v, e1);
      chk("R8 R9 random irq", int'(irq_out), (i1 << 1) | i0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule